// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two data buses, A and B, through a pair of storage registers. Each direction has a register clocked by its own clock, an output enable and a source select. The select picks whether the bus on the far side is driven with the data now on the near bus ("live") or with the value held in that direction's register ("stored"). The register for the A-to-B direction samples the resolved A bus. The register for the B-to-A direction samples the resolved B bus. A bus that the block itself drives therefore loops its own output back into the register on that side. This lets a single bus value be captured into both registers with one pair of clock edges.

Each bidirectional pad appears as three signals: an input, an output and an output enable. The pad logic around the block merges them. The A-to-B enable is active high and the B-to-A enable is active low. A parameter selects a data path that either passes the data unchanged or complements it. A synchronous clear is included so that tests can start the registers from a known value. In normal use the registers power up undefined.

Top module: `regxcvr_top`

## Requirements
- R1: `INVERT`=0 passes data unchanged to each output. `INVERT`=1 drives the bitwise complement on every path, live or stored. `WIDTH` defaults to 8.
- R2: On a rising edge of `clk_ab`, the A-to-B register loads the resolved A bus. On a rising edge of `clk_ba`, the B-to-A register loads the resolved B bus. A register whose clock has no rising edge keeps its value.
- R3: `b_oe` equals `en_ab`, so the B side is enabled by a high level. `a_oe` equals the inverse of `en_ba_n`, so the A side is enabled by a low level.
- R4: With `sel_ab`=0, `b_out` is the transformed resolved A bus. With `sel_ab`=1, `b_out` is the transformed A-to-B register. `sel_ba` chooses the source of `a_out` from the B bus or the B-to-A register in the same way.
- R5: With both sides disabled (`en_ab`=0, `en_ba_n`=1), the buses are isolated. Both registers still capture `a_in` and `b_in` independently on their clock edges.
- R6: The resolved bus on an enabled side is the block's own output. On a disabled side it is the external input. If B is driven live from A and both clocks rise, the A-to-B register takes `a_in` and the B-to-A register takes the transformed `a_in`. The mirror case holds for A driven live from B.
- R7: With both sides enabled and both selects at 1, `b_out` shows the transformed A-to-B register and `a_out` shows the transformed B-to-A register at the same time.
- R8: `clr` high at a rising edge of a register's clock sets that register to all zeros.
- R9: Both sides enabled with both selects at 0 (live in both directions) is an illegal input state. No combinational loop is built for it. Each direction then falls back to the external input of the other side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| clr | input | 1 | Synchronous clear, sampled on each register's own clock (test use) |
| en_ab | input | 1 | B-side output enable, active high |
| en_ba_n | input | 1 | A-side output enable, active low |
| sel_ab | input | 1 | B-side source: 0 live A bus, 1 A-to-B register |
| sel_ba | input | 1 | A-side source: 0 live B bus, 1 B-to-A register |
| a_in | input | WIDTH | Value received from the A pads |
| a_out | output | WIDTH | Value driven onto the A pads |
| a_oe | output | 1 | A pad output enable |
| b_in | input | WIDTH | Value received from the B pads |
| b_out | output | WIDTH | Value driven onto the B pads |
| b_oe | output | 1 | B pad output enable |

## Verification
The assertions are checked on edges of the two register clocks. They take three things for granted. Enables, selects and bus inputs are stable around each of those edges. The illegal dual-live state is never present at an edge. `clr` has been high for at least one edge of each clock before the capture checks begin. The stimulus changes inputs only half a reference period away from any register clock edge, and it pulses both register clocks under `clr` before anything else. Whenever it moves between modes, it raises the selects before the enables, so a dual-live state can never coincide with a clock edge.

// File: rtl/regxcvr_pkg.sv
package regxcvr_pkg;

  // Per-bit data-path transform: complement when inv is set.
  function automatic logic xbit(input logic d, input logic inv);
    return d ^ inv;
  endfunction

  // Resolved bus value as seen by the register on that side.
  function automatic logic rbit(input logic oe, input logic drive, input logic ext);
    return oe ? drive : ext;
  endfunction

endpackage

// File: rtl/regxcvr_store.sv
module regxcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // Captures on every rising edge; enables play no part here (R2, R5, R8).
  always_ff @(posedge clk) begin
    if (clr) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/regxcvr_xform.sv
module regxcvr_xform #(
  parameter int WIDTH  = 8,
  parameter int INVERT = 0
) (
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam logic INV_BIT = (INVERT != 0);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign q[i] = regxcvr_pkg::xbit(d[i], INV_BIT);
  end

endmodule

// File: rtl/regxcvr_path.sv
module regxcvr_path #(
  parameter int WIDTH  = 8,
  parameter int INVERT = 0
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] stored_x,
  input  logic [WIDTH-1:0] live,
  output logic [WIDTH-1:0] drive
);

  logic [WIDTH-1:0] live_x;

  regxcvr_xform #(.WIDTH(WIDTH), .INVERT(INVERT)) u_live (
    .d(live),
    .q(live_x)
  );

  assign drive = sel ? stored_x : live_x;

endmodule

// File: rtl/regxcvr_top.sv
module regxcvr_top #(
  parameter int WIDTH  = 8,
  parameter int INVERT = 0
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             clr,
  input  logic             en_ab,
  input  logic             en_ba_n,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  localparam logic INV_BIT = (INVERT != 0);

  logic [WIDTH-1:0] q_ab, q_ba;
  logic [WIDTH-1:0] q_ab_x, q_ba_x;
  logic [WIDTH-1:0] a_src_for_b, b_src_for_a;
  logic [WIDTH-1:0] a_bus, b_bus;
  logic             dual_live;

  // Enables: B side active high, A side active low (R3).
  assign b_oe = en_ab;
  assign a_oe = ~en_ba_n;

  // Named event for the illegal state (R9).
  assign dual_live = a_oe && b_oe && !sel_ab && !sel_ba;

  // Transformed register contents for the stored paths.
  regxcvr_xform #(.WIDTH(WIDTH), .INVERT(INVERT)) u_xab (.d(q_ab), .q(q_ab_x));
  regxcvr_xform #(.WIDTH(WIDTH), .INVERT(INVERT)) u_xba (.d(q_ba), .q(q_ba_x));

  // Far-side value feeding each live path. Only a stored drive on the far
  // side is looped in; a live far side falls back to its pad input (R9).
  assign a_src_for_b = (a_oe && sel_ba) ? q_ba_x : a_in;
  assign b_src_for_a = (b_oe && sel_ab) ? q_ab_x : b_in;

  regxcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_b (
    .sel(sel_ab), .stored_x(q_ab_x), .live(a_src_for_b), .drive(b_out)
  );

  regxcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_a (
    .sel(sel_ba), .stored_x(q_ba_x), .live(b_src_for_a), .drive(a_out)
  );

  // Resolved buses seen by the registers (R6 loopback).
  for (genvar i = 0; i < WIDTH; i++) begin : g_res
    assign a_bus[i] = regxcvr_pkg::rbit(a_oe, a_out[i], a_in[i]);
    assign b_bus[i] = regxcvr_pkg::rbit(b_oe, b_out[i], b_in[i]);
  end

  regxcvr_store #(.WIDTH(WIDTH)) u_reg_ab (.clk(clk_ab), .clr(clr), .d(a_bus), .q(q_ab));
  regxcvr_store #(.WIDTH(WIDTH)) u_reg_ba (.clk(clk_ba), .clr(clr), .d(b_bus), .q(q_ba));

  // R2: value held after an edge is the resolved A bus sampled at that edge.
  a_r2_ab_capture: assert property (@(posedge clk_ab) disable iff (clr)
    1'b1 |=> (q_ab == $past(a_bus)));

  // R2: same for the B-to-A register.
  a_r2_ba_capture: assert property (@(posedge clk_ba) disable iff (clr)
    1'b1 |=> (q_ba == $past(b_bus)));

  // R4 / R7: stored B drive reflects the A-to-B register.
  a_r4_b_stored: assert property (@(posedge clk_ab) disable iff (clr)
    (b_oe && sel_ab) |-> (b_out == (INV_BIT ? ~q_ab : q_ab)));

  // R4 / R7: stored A drive reflects the B-to-A register.
  a_r4_a_stored: assert property (@(posedge clk_ba) disable iff (clr)
    (a_oe && sel_ba) |-> (a_out == (INV_BIT ? ~q_ba : q_ba)));

  // R4 / R6: live B drive from an undriven A side follows the A pads.
  a_r6_b_live: assert property (@(posedge clk_ba) disable iff (clr)
    (b_oe && !sel_ab && !a_oe) |-> (b_out == (INV_BIT ? ~a_in : a_in)));

  // R9: no dual-live state at a capture edge.
  a_r9_no_dual_live_ab: assert property (@(posedge clk_ab) disable iff (clr)
    !dual_live);
  a_r9_no_dual_live_ba: assert property (@(posedge clk_ba) disable iff (clr)
    !dual_live);

endmodule

// File: tb/tb_regxcvr_top.sv
`timescale 1ns/1ps
module tb_regxcvr_top;

  logic       clk = 1'b0;
  logic       clk_ab = 1'b0, clk_ba = 1'b0, clr = 1'b1;
  logic       en_ab = 1'b0, en_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  logic [7:0] a_out, b_out, ai_out, bi_out;
  logic       a_oe, b_oe, ai_oe, bi_oe;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  regxcvr_top #(.WIDTH(8), .INVERT(0)) dut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .clr(clr), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  regxcvr_top #(.WIDTH(8), .INVERT(1)) dut_inv (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .clr(clr), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(ai_out), .a_oe(ai_oe),
    .b_in(b_in), .b_out(bi_out), .b_oe(bi_oe)
  );

  function automatic logic [7:0] fx(input logic [7:0] v, input bit inv);
    return inv ? (8'hFF - v) : v;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input bit do_ab, input bit do_ba);
    @(negedge clk);
    if (do_ab) clk_ab = 1'b1;
    if (do_ba) clk_ba = 1'b1;
    @(negedge clk);
    clk_ab = 1'b0;
    clk_ba = 1'b0;
    #1;
  endtask

  // Both sides enabled, both from registers (selects first).
  task automatic mode_stored_both();
    sel_ab = 1'b1; sel_ba = 1'b1;
    en_ab = 1'b1; en_ba_n = 1'b0;
    #1;
  endtask

  task automatic mode_isolate();
    en_ab = 1'b0; en_ba_n = 1'b1;
    sel_ab = 1'b0; sel_ba = 1'b0;
    #1;
  endtask

  task automatic chk_stored(input string req, input logic [7:0] q_ab_exp, input logic [7:0] q_ba_exp);
    chk(req, b_out,  fx(q_ab_exp, 0));
    chk(req, a_out,  fx(q_ba_exp, 0));
    chk(req, bi_out, fx(q_ab_exp, 1));
    chk(req, ai_out, fx(q_ba_exp, 1));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] last_w;
    logic [7:0] qi_ab, qi_ba;
    last_w = '0;

    // R8: clear both registers.
    repeat (2) @(negedge clk);
    pulse(1, 1);
    clr = 1'b0;
    mode_stored_both();
    chk_stored("R8 reset clear", 8'h00, 8'h00);

    // R3: enable polarities over all four combinations.
    for (int e = 0; e < 4; e++) begin
      sel_ab = 1'b1; sel_ba = 1'b1;
      en_ab = e[0]; en_ba_n = e[1];
      #1;
      chk("R3 b_oe", {7'd0, b_oe},  {7'd0, e[0]});
      chk("R3 a_oe", {7'd0, a_oe},  {7'd0, ~e[1]});
      chk("R3 inv b_oe", {7'd0, bi_oe}, {7'd0, e[0]});
      chk("R3 inv a_oe", {7'd0, ai_oe}, {7'd0, ~e[1]});
    end

    // R4 / R1: exhaustive live A to B.
    sel_ab = 1'b0; sel_ba = 1'b0; en_ba_n = 1'b1; en_ab = 1'b1;
    for (int v = 0; v < 256; v++) begin
      a_in = v[7:0]; b_in = ~v[7:0];
      #1;
      chk("R4 live A->B", b_out,  fx(v[7:0], 0));
      chk("R1 inverted live A->B", bi_out, fx(v[7:0], 1));
    end

    // R4 / R1: exhaustive live B to A.
    en_ab = 1'b0; en_ba_n = 1'b0;
    for (int v = 0; v < 256; v++) begin
      b_in = v[7:0]; a_in = ~v[7:0];
      #1;
      chk("R4 live B->A", a_out,  fx(v[7:0], 0));
      chk("R1 inverted live B->A", ai_out, fx(v[7:0], 1));
    end

    // R5 / R7: isolated captures, then both stored at once.
    for (int k = 0; k < 32; k++) begin
      logic [7:0] v, w;
      v = 8'(k * 37 + 5);
      w = 8'(k * 11 + 200);
      mode_isolate();
      a_in = v; b_in = w;
      pulse(1, 1);
      mode_stored_both();
      a_in = ~v; b_in = ~w;
      #1;
      chk_stored("R5 R7 isolate store", v, w);
      last_w = w;
    end

    // R2: only the A-to-B clock rises; B-to-A register holds.
    mode_isolate();
    a_in = 8'h3C; b_in = 8'hC3;
    pulse(1, 0);
    mode_stored_both();
    chk_stored("R2 hold", 8'h3C, last_w);

    // R6: B live from A, both clocks; both registers load the A value.
    mode_isolate();
    en_ab = 1'b1;
    a_in = 8'h5A; b_in = 8'h0F;
    pulse(1, 1);
    mode_stored_both();
    chk("R6 A loop b", b_out,  8'h5A);
    chk("R6 A loop a", a_out,  8'h5A);
    chk("R6 A loop inv b", bi_out, 8'hA5);
    chk("R6 A loop inv a", ai_out, 8'h5A);

    // R6 mirror: A live from B.
    mode_isolate();
    en_ba_n = 1'b0;
    b_in = 8'h96; a_in = 8'h11;
    pulse(1, 1);
    mode_stored_both();
    chk("R6 B loop a", a_out,  8'h96);
    chk("R6 B loop b", b_out,  8'h96);
    chk("R6 B loop inv a", ai_out, 8'h69);
    chk("R6 B loop inv b", bi_out, 8'h96);

    // R8: clear only the A-to-B register.
    qi_ab = 8'h69; qi_ba = 8'h96;
    clr = 1'b1;
    pulse(1, 0);
    clr = 1'b0;
    #1;
    chk("R8 clear ab", b_out, 8'h00);
    chk("R8 keep ba",  a_out, 8'h96);
    chk("R8 inv clear ab", bi_out, 8'hFF);
    chk("R8 inv keep ba",  ai_out, fx(qi_ba, 1));
    if (qi_ab == 8'h00) chk("R8 note", 8'h00, 8'h01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule